// File: doc/BRIEF.md
# Timer-Paced Asynchronous Serial Port

This block is a full-duplex asynchronous serial port whose bit rate is set by an 8-bit auto-reloading timer. The oscillator clock is divided by 12 into machine-cycle ticks. Each tick advances the timer while the timer is running. Every timer overflow reloads the count from a programmable reload byte. The overflows form a 32x oversampling clock for the receiver. A divide-by-32 stage turns them into the bit clock for the transmitter.

Software writes four configuration locations over a simple write port: a timer mode byte, a reload byte, a serial control byte and a transmit buffer. The control byte selects the serial mode and enables reception. It also holds the two sticky flags, transmit-done and receive-full. A write to the control byte sets both flags to the written values, so writing 0x50 clears them. With a reload of 0xFD and an 11.0592 MHz oscillator the port runs at 9600 baud.

Top module: `timed_serial_port`

## Requirements
- R1: After reset, txd is high, tx_done and rx_full are 0 and rx_byte is 0x00.
- R2: The timer advances only while timer-mode bits [5:4] hold 2'b10 (for example 0x20). A byte accepted while the timer is stopped stays on hold and is sent once the timer starts.
- R3: One bit lasts 12 * 32 * (256 - reload) oscillator clocks. A reload of 0xFD gives 1152 clocks per bit.
- R4: The transmitter sends one low start bit, then 8 data bits with the LSB first, then one high stop bit. The line idles high.
- R5: tx_done sets when the stop bit goes onto the line. It stays set until a write to control address 2 puts bit 1 to 0.
- R6: A frame received with a high stop bit while rx_full is clear is placed in rx_byte, and rx_full sets. rx_full is control bit 0 and stays set until written to 0.
- R7: A low pulse on rxd that is high again when the start bit is sampled at its centre is dropped as a false start. No byte is stored and the receiver stays ready for the next frame.
- R8: A frame that completes while rx_full is set is discarded, and rx_byte keeps its old value.
- R9: A frame whose stop bit samples low is discarded.
- R10: With the receive-enable bit (control bit 4) at 0, incoming frames are ignored.
- R11: Transmission and reception proceed at the same time without disturbing each other.
- R12: A write to the transmit buffer (address 3) while a frame is in progress is ignored.
- R13: A transmit-buffer write is accepted only when control bits [7:6] equal 2'b01. Otherwise no frame is sent and tx_done stays clear.

Register addresses: 0 = timer mode, 1 = reload (a write also loads the timer count), 2 = serial control, 3 = transmit buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_byte | output | 8 | Last byte accepted by the receiver |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_full | output | 1 | Sticky receive-full flag |

## Verification
The bench counts the clocks between the edges of an all-zero frame at reload 0xFD. A prescaler or divider that is off by one shows up as an exact clock mismatch there. Several byte patterns go through a loopback and are also sampled at bit centres on the line. This catches a bit order, a start polarity or a stop polarity that is wrong. A short glitch, a frame with a low stop bit and a frame that arrives while rx_full is set must all leave rx_byte unchanged; a receiver that skips the mid-start check, ignores the stop bit or overwrites a full buffer would store a byte. A second buffer write during a frame, a write in the wrong serial mode and a write while the timer is stopped each check that an unwanted frame is not sent and a held one is not lost.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    REG_TMODE  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_SCTRL  = 2'd2,
    REG_TXBUF  = 2'd3
  } reg_sel_e;

  localparam logic [1:0] TMR_AUTO_RELOAD = 2'b10;
  localparam logic [1:0] SER_MODE_VAR8   = 2'b01;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mc_prescaler.sv
module mc_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    tick_d = (cnt_q == LAST);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (load_en) begin
      cnt_d = load_val;
    end else if (step) begin
      if (&cnt_q) begin
        cnt_d = reload;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf   <= ovf_d;
    end
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  output logic bit_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (ovf) begin
      tick_d = (cnt_q == LAST);
      cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      bit_tick <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      bit_tick <= tick_d;
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          stop_pulse
);
  localparam int FW = DW + 2;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] frame_q, frame_d;
  logic [LW-1:0] left_q, left_d;
  logic          busy_d, txd_d, stop_d;

  always_comb begin
    frame_d = frame_q;
    left_d  = left_q;
    busy_d  = busy;
    txd_d   = txd;
    stop_d  = 1'b0;
    if (start && !busy) begin
      frame_d = {1'b1, data, 1'b0};
      left_d  = LW'(FW);
      busy_d  = 1'b1;
    end else if (bit_tick && busy) begin
      if (left_q == '0) begin
        busy_d = 1'b0;
      end else begin
        txd_d   = frame_q[0];
        frame_d = {1'b1, frame_q[FW-1:1]};
        left_d  = left_q - 1'b1;
        stop_d  = (left_q == LW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q    <= '1;
      left_q     <= '0;
      busy       <= 1'b0;
      txd        <= 1'b1;
      stop_pulse <= 1'b0;
    end else begin
      frame_q    <= frame_d;
      left_q     <= left_d;
      busy       <= busy_d;
      txd        <= txd_d;
      stop_pulse <= stop_d;
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import sp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          sample_tick,
  input  logic          rxd,
  input  logic          buf_full,
  output logic          load,
  output logic [DW-1:0] data
);
  localparam int PW = $clog2(OVS);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [PW-1:0] MID  = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OVS - 1);
  localparam logic [IW-1:0] LAST_BIT = IW'(DW - 1);

  logic          sync1_q, sync2_q, prev_q;
  rx_state_e     st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_d;
  logic          load_d, mid;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    sh_d   = data;
    load_d = 1'b0;
    mid    = sample_tick && (ph_q == MID);
    if (st_q != RX_IDLE && sample_tick) begin
      ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
    case (st_q)
      RX_IDLE: begin
        if (enable && prev_q && !sync2_q) begin
          st_d = RX_START;
          ph_d = '0;
        end
      end
      RX_START: begin
        if (mid) begin
          st_d  = sync2_q ? RX_IDLE : RX_DATA;
          idx_d = '0;
        end
      end
      RX_DATA: begin
        if (mid) begin
          sh_d = {sync2_q, data[DW-1:1]};
          if (idx_q == LAST_BIT) st_d = RX_STOP;
          else idx_d = idx_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (mid) begin
          st_d   = RX_IDLE;
          load_d = sync2_q && !buf_full;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      data    <= '0;
      load    <= 1'b0;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      st_q    <= st_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      data    <= sh_d;
      load    <= load_d;
    end
  end
endmodule

// File: rtl/timed_serial_port.sv
module timed_serial_port
  import sp_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int BAUD_DIV   = 32,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          rxd,
  output logic          txd,
  output logic [DW-1:0] rx_byte,
  output logic          tx_done,
  output logic          rx_full
);
  logic [1:0]    tmr_mode_q, tmr_mode_d;
  logic [DW-1:0] reload_q, reload_d;
  logic [1:0]    ser_mode_q, ser_mode_d;
  logic          ren_q, ren_d;
  logic          tx_done_d, rx_full_d;
  logic [DW-1:0] rx_byte_d;

  logic we_tmode, we_reload, we_sctrl, we_txbuf;
  logic mc_tick, tmr_run, ovf, bit_tick;
  logic tx_busy, tx_stop, rx_load;
  logic [DW-1:0] rx_data;

  always_comb begin
    we_tmode  = cfg_we && (cfg_addr == REG_TMODE);
    we_reload = cfg_we && (cfg_addr == REG_RELOAD);
    we_sctrl  = cfg_we && (cfg_addr == REG_SCTRL);
    we_txbuf  = cfg_we && (cfg_addr == REG_TXBUF);
    tmr_run   = (tmr_mode_q == TMR_AUTO_RELOAD);

    tmr_mode_d = we_tmode  ? cfg_wdata[5:4] : tmr_mode_q;
    reload_d   = we_reload ? cfg_wdata      : reload_q;
    ser_mode_d = we_sctrl  ? cfg_wdata[7:6] : ser_mode_q;
    ren_d      = we_sctrl  ? cfg_wdata[4]   : ren_q;

    tx_done_d = tx_done;
    if (we_sctrl) tx_done_d = cfg_wdata[1];
    if (tx_stop)  tx_done_d = 1'b1;

    rx_full_d = rx_full;
    rx_byte_d = rx_byte;
    if (we_sctrl) rx_full_d = cfg_wdata[0];
    if (rx_load) begin
      rx_full_d = 1'b1;
      rx_byte_d = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_mode_q <= '0;
      reload_q   <= '0;
      ser_mode_q <= '0;
      ren_q      <= 1'b0;
      tx_done    <= 1'b0;
      rx_full    <= 1'b0;
      rx_byte    <= '0;
    end else begin
      tmr_mode_q <= tmr_mode_d;
      reload_q   <= reload_d;
      ser_mode_q <= ser_mode_d;
      ren_q      <= ren_d;
      tx_done    <= tx_done_d;
      rx_full    <= rx_full_d;
      rx_byte    <= rx_byte_d;
    end
  end

  mc_prescaler #(.DIV(OSC_PER_MC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick)
  );

  reload_timer #(.W(DW)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .step(mc_tick && tmr_run),
    .load_en(we_reload), .load_val(cfg_wdata),
    .reload(reload_q), .ovf(ovf)
  );

  baud_divider #(.DIV(BAUD_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .bit_tick(bit_tick)
  );

  serial_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .start(we_txbuf && (ser_mode_q == SER_MODE_VAR8)),
    .data(cfg_wdata), .txd(txd), .busy(tx_busy), .stop_pulse(tx_stop)
  );

  serial_rx #(.DW(DW), .OVS(BAUD_DIV)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .enable(ren_q && (ser_mode_q == SER_MODE_VAR8)),
    .sample_tick(ovf), .rxd(rxd), .buf_full(rx_full),
    .load(rx_load), .data(rx_data)
  );
endmodule

// File: rtl/timed_serial_port_chk.sv
module timed_serial_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic          txd,
  input logic          tx_done,
  input logic          rx_full,
  input logic [DW-1:0] rx_byte,
  input logic          bit_tick
);
  logic wr_ctrl;
  assign wr_ctrl = cfg_we && (cfg_addr == 2'd2);

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (txd && !tx_done && !rx_full));

  a_r5_tx_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !wr_ctrl) |=> tx_done);

  a_r6_rx_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !wr_ctrl) |=> rx_full);

  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_byte));

  a_r4_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));
endmodule

bind timed_serial_port timed_serial_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .txd(txd), .tx_done(tx_done), .rx_full(rx_full), .rx_byte(rx_byte),
  .bit_tick(bit_tick)
);

// File: tb/timed_serial_port_test.sv
module timed_serial_port_test;
  localparam int CLK_P = 10;
  localparam int BIT_FF = 12 * 32 * (256 - 255);
  localparam int BIT_FD = 12 * 32 * (256 - 253);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       loop_en, drv;
  logic       txd, tx_done, rx_full;
  logic [7:0] rx_byte;
  wire        rxd = loop_en ? txd : drv;

  int errors = 0;
  int checks = 0;
  int bit_clks = BIT_FF;

  timed_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rxd(rxd), .txd(txd), .rx_byte(rx_byte),
    .tx_done(tx_done), .rx_full(rx_full)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * bit_clks) @(negedge clk);
  endtask

  task automatic count_lows(input int n, output int lows);
    lows = 0;
    repeat (n * bit_clks) begin
      @(negedge clk);
      if (!txd) lows++;
    end
  endtask

  task automatic capture(output logic [7:0] b, output logic stopv, output logic startv);
    int t = 0;
    b = 8'h00; stopv = 1'b0; startv = 1'b1;
    while (txd && t < 20 * bit_clks) begin @(negedge clk); t++; end
    repeat (bit_clks / 2) @(negedge clk);
    startv = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (bit_clks) @(negedge clk);
      b[i] = txd;
    end
    repeat (bit_clks) @(negedge clk);
    stopv = txd;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    drv = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv = b[i];
      repeat (bit_clks) @(negedge clk);
    end
    drv = stopv;
    repeat (bit_clks) @(negedge clk);
    drv = 1'b1;
  endtask

  task automatic wait_rx(input int limit);
    int t = 0;
    while (!rx_full && t < limit) begin @(negedge clk); t++; end
  endtask

  task automatic wait_tx(input int limit);
    int t = 0;
    while (!tx_done && t < limit) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] cap;
    logic       sb, st;
    int         lows;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 8'h00;
    loop_en = 1'b1; drv = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(!tx_done && !rx_full, "R1 flags", int'({tx_done, rx_full}), 0);
    chk(rx_byte == 8'h00, "R1 rx_byte", int'(rx_byte), 0);

    // R13: wrong serial mode, write ignored
    wr(2'd2, 8'h10); wr(2'd1, 8'hFF); wr(2'd0, 8'h20);
    wr(2'd3, 8'h3C);
    count_lows(12, lows);
    chk(lows == 0, "R13 no frame in mode 0", lows, 0);
    chk(!tx_done, "R13 tx_done clear", int'(tx_done), 0);

    // R2: timer stopped holds the frame
    wr(2'd0, 8'h00); wr(2'd2, 8'h50);
    wr(2'd3, 8'hC3);
    count_lows(3, lows);
    chk(lows == 0, "R2 held while timer stopped", lows, 0);
    fork
      capture(cap, sb, st);
      wr(2'd0, 8'h20);
    join
    chk(cap == 8'hC3, "R2 held byte sent", int'(cap), 8'hC3);
    wait_tx(4 * bit_clks);
    chk(tx_done, "R5 tx_done set", int'(tx_done), 1);
    wait_bits(3);
    chk(tx_done, "R5 tx_done sticky", int'(tx_done), 1);
    wr(2'd2, 8'h50);
    chk(!tx_done && !rx_full, "R5 flags cleared by write", int'({tx_done, rx_full}), 0);

    // R3: bit period at reload 0xFD
    bit_clks = BIT_FD;
    wr(2'd1, 8'hFD);
    wr(2'd3, 8'h00);
    begin
      int t = 0;
      while (txd && t < 20 * BIT_FD) begin @(posedge clk); #1; t++; end
      lows = 0;
      while (!txd && lows < 20 * BIT_FD) begin @(posedge clk); #1; lows++; end
    end
    chk(lows == 9 * BIT_FD, "R3 nine low bits at 0xFD", lows, 9 * BIT_FD);
    wait_bits(2);
    wr(2'd2, 8'h50);
    bit_clks = BIT_FF;
    wr(2'd1, 8'hFF);

    // R4/R6: loopback sweep of byte patterns
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      case (i)
        0: b = 8'h00;
        1: b = 8'hFF;
        2: b = 8'h55;
        3: b = 8'hAA;
        default: b = 8'((i * 53 + 7) & 8'hFF);
      endcase
      fork
        capture(cap, sb, st);
        wr(2'd3, b);
      join
      chk(cap == b, "R4 line data LSB first", int'(cap), int'(b));
      chk(st == 1'b0 && sb == 1'b1, "R4 start low stop high", int'({st, sb}), 1);
      wait_rx(2 * bit_clks);
      chk(rx_full && rx_byte == b, "R6 loopback byte", int'(rx_byte), int'(b));
      wait_bits(2);
      wr(2'd2, 8'h50);
    end

    loop_en = 1'b0;
    // R7: false start
    @(negedge clk); drv = 1'b0;
    repeat (bit_clks / 4) @(negedge clk);
    drv = 1'b1;
    wait_bits(12);
    chk(!rx_full, "R7 glitch dropped", int'(rx_full), 0);
    send_frame(8'h5A, 1'b1);
    wait_rx(bit_clks);
    chk(rx_full && rx_byte == 8'h5A, "R7 ready after false start", int'(rx_byte), 8'h5A);
    wr(2'd2, 8'h50);

    // R9: low stop bit
    send_frame(8'h77, 1'b0);
    wait_bits(3);
    chk(!rx_full && rx_byte == 8'h5A, "R9 framing error discarded", int'(rx_byte), 8'h5A);
    send_frame(8'h78, 1'b1);
    wait_rx(bit_clks);
    chk(rx_byte == 8'h78, "R9 next good frame", int'(rx_byte), 8'h78);
    wr(2'd2, 8'h50);

    // R8: overrun
    send_frame(8'h11, 1'b1);
    wait_rx(bit_clks);
    send_frame(8'h22, 1'b1);
    wait_bits(1);
    chk(rx_full && rx_byte == 8'h11, "R8 full buffer kept", int'(rx_byte), 8'h11);
    wr(2'd2, 8'h50);
    send_frame(8'h33, 1'b1);
    wait_rx(bit_clks);
    chk(rx_byte == 8'h33, "R8 accepts after clear", int'(rx_byte), 8'h33);
    wr(2'd2, 8'h50);

    // R10: receive disabled
    wr(2'd2, 8'h40);
    send_frame(8'h44, 1'b1);
    wait_bits(2);
    chk(!rx_full && rx_byte == 8'h33, "R10 ignored when disabled", int'(rx_byte), 8'h33);
    wr(2'd2, 8'h50);

    // R11: full duplex
    fork
      send_frame(8'h9E, 1'b1);
      wr(2'd3, 8'h61);
      capture(cap, sb, st);
    join
    wait_rx(2 * bit_clks);
    chk(cap == 8'h61, "R11 tx during rx", int'(cap), 8'h61);
    chk(rx_full && rx_byte == 8'h9E, "R11 rx during tx", int'(rx_byte), 8'h9E);
    wait_bits(2);
    wr(2'd2, 8'h50);

    // R12: write during frame ignored
    fork
      capture(cap, sb, st);
      begin
        wr(2'd3, 8'hE7);
        wait_bits(3);
        wr(2'd3, 8'h18);
      end
    join
    chk(cap == 8'hE7, "R12 first byte intact", int'(cap), 8'hE7);
    wait_bits(2);
    count_lows(12, lows);
    chk(lows == 0, "R12 second write not sent", lows, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule